// File: doc/BRIEF.md
# Fixed-Latency Tagged Function Pipe

This block is an execution pipe that serves one class of operation. A dispatch stage offers it an instruction token made of a warp number, an active-lane mask and an op-class code. If the code matches the class the pipe was built for, and the pipe can take a token in that cycle, the token is accepted. The pipe marks it as running on the dedicated pipe, carries it through a chain of delay stages, and returns it on the writeback port a fixed number of cycles later. Tokens with another class are refused. The pipe does no arithmetic: it models only the timing and occupancy of such a unit. Several copies may be instantiated for one class.

Latency and initiation interval are separate parameters, so the same block covers a short branch pipe (4/4), a matrix pipe (8/4), a long sampler pipe (200/4) or a fast uniform pipe (4/2). The issue gate is a two-state machine. In `GATE_OPEN` the pipe may accept. When a token is accepted and the interval is longer than one cycle, the `open_to_cool` transition moves it to `GATE_COOL`, where a counter holds off the next token. The `cool_to_open` transition returns it to `GATE_OPEN` when the counter reaches zero. When the writeback consumer stalls, the whole chain freezes. The pipe also reports how many distinct lanes are busy in flight.

Top module: `fpipe_unit`

## Requirements
- R1: After reset, `wb_valid` is 0, `lanes_busy` is 0 and `in_ready` is 1 while `in_cls` equals `UNIT_CLASS` and `wb_stall` is 0.
- R2: A token whose `in_cls` differs from `UNIT_CLASS` is refused: `in_ready` is 0 and the token never appears on the writeback port, so every `wb_cls` equals `UNIT_CLASS`.
- R3: A token accepted in cycle k (`in_valid` and `in_ready` both 1) appears on the writeback port in cycle k+LATENCY, with the same warp, mask and class, if no stall occurs in between.
- R4: After an accept in cycle k, `in_ready` is 0 in cycles k+1 to k+INIT_II-1 and returns to 1 in cycle k+INIT_II.
- R5: Tokens leave in the order they were accepted, and none is lost or duplicated.
- R6: While `wb_stall` is 1, `in_ready` is 0, the pipe does not advance, and the writeback outputs hold their values. Each stall cycle delays every token in flight by one cycle.
- R7: Every token on the writeback port carries the dedicated-pipe tag, `wb_spec` = 1.
- R8: `lanes_busy` equals the population count of the bitwise OR of the masks of all occupied stages, and never exceeds `WARP_SZ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Dispatch offers a token |
| in_warp | input | WARP_ID_W | Warp number of the offered token |
| in_mask | input | WARP_SZ | Active-lane mask of the offered token |
| in_cls | input | CLASS_W | Op-class code of the offered token |
| in_ready | output | 1 | Pipe accepts the offered token this cycle |
| wb_valid | output | 1 | Token present on the writeback port |
| wb_warp | output | WARP_ID_W | Writeback warp number |
| wb_mask | output | WARP_SZ | Writeback lane mask |
| wb_cls | output | CLASS_W | Writeback op-class code |
| wb_spec | output | 1 | Dedicated-pipe tag of the writeback token |
| wb_stall | input | 1 | Writeback consumer cannot take a token; the pipe freezes |
| lanes_busy | output | $clog2(WARP_SZ+1) | Distinct active lanes in flight |

## Verification
On every cycle, the assertions check the lane bound, the class of outgoing tokens, the tag, the one-cycle hold of the writeback outputs after a stall, and the closed gate in the cycle after an accept. Only the bench scenarios can show the exact latency in cycles, including the shift added by stalls. They also show the full length of the interval, first-in first-out order with nothing lost, and the exact lane count for overlapping masks. The bench scoreboard records each accept cycle and compares every departure against it.

// File: rtl/fpipe_pkg.sv
package fpipe_pkg;

    typedef enum logic [0:0] {
        GATE_OPEN = 1'b0,
        GATE_COOL = 1'b1
    } gate_state_e;

endpackage

// File: rtl/fpipe_issue_gate.sv
module fpipe_issue_gate
    import fpipe_pkg::*;
#(
    parameter int INIT_II = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic cls_ok,
    input  logic stall,
    output logic ready,
    output logic fire
);
    localparam int CNT_W     = (INIT_II > 2) ? $clog2(INIT_II - 1) : 1;
    localparam int COOL_INIT = (INIT_II > 1) ? INIT_II - 2 : 0;

    gate_state_e        state, state_nx;
    logic [CNT_W-1:0]   cool_cnt;

    // output process
    always_comb begin
        ready = (state == GATE_OPEN) && cls_ok && !stall;
        fire  = ready && req_valid;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_OPEN: if (fire && (INIT_II > 1)) state_nx = GATE_COOL;   // open_to_cool
            GATE_COOL: if (cool_cnt == '0)        state_nx = GATE_OPEN;   // cool_to_open
            default:                              state_nx = GATE_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= GATE_OPEN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cool_cnt <= '0;
        else if (fire)
            cool_cnt <= CNT_W'(COOL_INIT);
        else if (state == GATE_COOL && cool_cnt != '0)
            cool_cnt <= cool_cnt - 1'b1;
    end

    generate
        if (INIT_II > 1) begin : g_gap_chk
            AST_COOL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                fire |=> !ready);   // R4
        end
    endgenerate

endmodule

// File: rtl/fpipe_delay_line.sv
module fpipe_delay_line #(
    parameter int DEPTH = 8,
    parameter int PW    = 43
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic                load,
    input  logic [PW-1:0]       load_pay,
    output logic [DEPTH-1:0]    stage_vld,
    output logic [DEPTH*PW-1:0] stage_pay
);
    logic [DEPTH-1:0]  vld_q;
    logic [PW-1:0]     pay_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            pay_q[0] <= '0;
        end else if (advance) begin
            vld_q[0] <= load;
            pay_q[0] <= load ? load_pay : '0;
        end
    end

    generate
        for (genvar s = 1; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    pay_q[s] <= '0;
                end else if (advance) begin
                    vld_q[s] <= vld_q[s-1];
                    pay_q[s] <= pay_q[s-1];
                end
            end
        end
        for (genvar s = 0; s < DEPTH; s++) begin : g_flat
            assign stage_pay[s*PW +: PW] = pay_q[s];
        end
    endgenerate

    assign stage_vld = vld_q;

endmodule

// File: rtl/fpipe_lane_tally.sv
module fpipe_lane_tally #(
    parameter int DEPTH = 8,
    parameter int LANES = 32,
    parameter int CNT_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEPTH-1:0]       vld,
    input  logic [DEPTH*LANES-1:0] masks,
    output logic [CNT_W-1:0]       busy
);
    logic [LANES-1:0] lane_union;

    always_comb begin
        lane_union = '0;
        for (int s = 0; s < DEPTH; s++)
            if (vld[s]) lane_union = lane_union | masks[s*LANES +: LANES];
        busy = CNT_W'($countones(lane_union));
    end

    AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy <= CNT_W'(LANES));   // R8

endmodule

// File: rtl/fpipe_unit.sv
module fpipe_unit #(
    parameter int WARP_SZ    = 32,
    parameter int WARP_ID_W  = 6,
    parameter int CLASS_W    = 4,
    parameter int UNIT_CLASS = 1,
    parameter int LATENCY    = 8,
    parameter int INIT_II    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [WARP_ID_W-1:0]         in_warp,
    input  logic [WARP_SZ-1:0]           in_mask,
    input  logic [CLASS_W-1:0]           in_cls,
    output logic                         in_ready,
    output logic                         wb_valid,
    output logic [WARP_ID_W-1:0]         wb_warp,
    output logic [WARP_SZ-1:0]           wb_mask,
    output logic [CLASS_W-1:0]           wb_cls,
    output logic                         wb_spec,
    input  logic                         wb_stall,
    output logic [$clog2(WARP_SZ+1)-1:0] lanes_busy
);
    localparam int PAY_W   = 1 + CLASS_W + WARP_ID_W + WARP_SZ;
    localparam int MASK_LO = 0;
    localparam int WARP_LO = WARP_SZ;
    localparam int CLS_LO  = WARP_SZ + WARP_ID_W;
    localparam int SPEC_B  = PAY_W - 1;
    localparam int LCNT_W  = $clog2(WARP_SZ + 1);

    logic                     cls_ok, fire;
    logic [PAY_W-1:0]         issue_pay;
    logic [LATENCY-1:0]       stage_vld;
    logic [LATENCY*PAY_W-1:0] stage_pay;
    logic [LATENCY*WARP_SZ-1:0] stage_masks;
    logic [PAY_W-1:0]         tail_pay;

    assign cls_ok = (in_cls == CLASS_W'(UNIT_CLASS));

    fpipe_issue_gate #(.INIT_II(INIT_II)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (in_valid),
        .cls_ok    (cls_ok),
        .stall     (wb_stall),
        .ready     (in_ready),
        .fire      (fire)
    );

    // tag the token as running on the dedicated pipe before it enters the chain
    assign issue_pay = {1'b1, in_cls, in_warp, in_mask};

    fpipe_delay_line #(.DEPTH(LATENCY), .PW(PAY_W)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (!wb_stall),
        .load      (fire),
        .load_pay  (issue_pay),
        .stage_vld (stage_vld),
        .stage_pay (stage_pay)
    );

    generate
        for (genvar s = 0; s < LATENCY; s++) begin : g_mask
            assign stage_masks[s*WARP_SZ +: WARP_SZ] = stage_pay[s*PAY_W + MASK_LO +: WARP_SZ];
        end
    endgenerate

    fpipe_lane_tally #(.DEPTH(LATENCY), .LANES(WARP_SZ), .CNT_W(LCNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (stage_vld),
        .masks (stage_masks),
        .busy  (lanes_busy)
    );

    assign tail_pay = stage_pay[(LATENCY-1)*PAY_W +: PAY_W];
    assign wb_valid = stage_vld[LATENCY-1];
    assign wb_mask  = tail_pay[MASK_LO +: WARP_SZ];
    assign wb_warp  = tail_pay[WARP_LO +: WARP_ID_W];
    assign wb_cls   = tail_pay[CLS_LO +: CLASS_W];
    assign wb_spec  = tail_pay[SPEC_B];

    AST_WB_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_spec);   // R7

    AST_WB_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_cls == CLASS_W'(UNIT_CLASS)));   // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stall && wb_valid) |=> (wb_valid && $stable(wb_warp) && $stable(wb_mask)));   // R6

endmodule

// File: tb/sim_fpipe_unit.sv
`timescale 1ns/1ps
module sim_fpipe_unit;
    localparam int LAT = 8;
    localparam int II  = 4;
    localparam int CLS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_warp = '0;
    logic [31:0] in_mask = '0;
    logic [3:0]  in_cls = '0;
    logic        in_ready;
    logic        wb_valid;
    logic [5:0]  wb_warp;
    logic [31:0] wb_mask;
    logic [3:0]  wb_cls;
    logic        wb_spec;
    logic        wb_stall = 1'b0;
    logic [5:0]  lanes_busy;

    always #2 clk = ~clk;

    fpipe_unit #(.WARP_SZ(32), .WARP_ID_W(6), .CLASS_W(4), .UNIT_CLASS(CLS),
                 .LATENCY(LAT), .INIT_II(II)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_warp(in_warp),
        .in_mask(in_mask), .in_cls(in_cls), .in_ready(in_ready),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_mask(wb_mask),
        .wb_cls(wb_cls), .wb_spec(wb_spec), .wb_stall(wb_stall),
        .lanes_busy(lanes_busy)
    );

    typedef struct {
        logic [5:0]  warp;
        logic [31:0] mask;
        logic [3:0]  cls;
        int          acc_cyc;
        int          stall_snap;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   stall_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // driver: offers a token, waits for acceptance, records the expectation
    task automatic send(input logic [5:0] w, input logic [31:0] m);
        exp_t e;
        @(posedge clk); #1;
        in_valid = 1'b1; in_warp = w; in_mask = m; in_cls = CLS[3:0];
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        e.warp = w; e.mask = m; e.cls = CLS[3:0];
        e.acc_cyc = cyc; e.stall_snap = stall_cnt;
        exp_q.push_back(e);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // monitor: compares each departing token with the head of the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (wb_stall) stall_cnt++;
            if (wb_valid && !wb_stall) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected writeback warp", wb_warp, 0);
                end else begin
                    exp_t e;
                    int   due;
                    e = exp_q.pop_front();
                    due = e.acc_cyc + LAT + (stall_cnt - e.stall_snap);
                    chk(cyc == due, "R3", "departure cycle", cyc, due);
                    chk(wb_warp == e.warp, "R5", "warp order", wb_warp, e.warp);
                    chk(wb_mask == e.mask, "R3", "mask", wb_mask, e.mask);
                    chk(wb_cls == e.cls, "R2", "class", wb_cls, e.cls);
                    chk(wb_spec == 1'b1, "R7", "tag", wb_spec, 1);
                end
            end
        end
    end

    task automatic drain();
        repeat (LAT + 6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "run timed out", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        in_cls = CLS[3:0];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(wb_valid == 1'b0, "R1", "wb_valid", wb_valid, 0);
        chk(lanes_busy == 0, "R1", "lanes_busy", lanes_busy, 0);
        chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);

        // R2: wrong class is refused and never emerges
        @(posedge clk); #1;
        in_valid = 1'b1; in_warp = 6'd9; in_mask = 32'hFFFF_FFFF; in_cls = 4'd2;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R2", "ready on mismatch", in_ready, 0);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_cls = CLS[3:0];
        drain();
        chk(lanes_busy == 0, "R2", "lanes after refused token", lanes_busy, 0);

        // R3 and R4: single token, then the interval
        send(6'd1, 32'h0000_00F0);
        for (int j = 1; j <= II; j++) begin
            @(negedge clk);
            chk(in_ready == (j == II), "R4", "ready during interval", in_ready, (j == II));
        end
        drain();

        // R8: overlapping masks counted once
        send(6'd2, 32'h0000_00FF);
        send(6'd3, 32'h0000_0FF0);
        @(negedge clk);
        chk(lanes_busy == 12, "R8", "union of two masks", lanes_busy, 12);
        drain();
        chk(lanes_busy == 0, "R8", "lanes after drain", lanes_busy, 0);

        // R8: full masks never exceed the warp size
        send(6'd4, 32'hFFFF_FFFF);
        send(6'd5, 32'hFFFF_FFFF);
        @(negedge clk);
        chk(lanes_busy == 32, "R8", "full masks", lanes_busy, 32);
        drain();

        // R5: stream of tokens keeps order
        for (int k = 0; k < 6; k++) send(6'(10 + k), 32'h1 << (k * 5));
        drain();

        // R6: stall freezes the pipe and closes the gate
        send(6'd20, 32'hA5A5_0000);
        send(6'd21, 32'h0000_5A5A);
        do begin @(posedge clk); #1; end while (!wb_valid);
        begin
            logic [5:0]  held_w;
            logic [31:0] held_m;
            held_w = wb_warp; held_m = wb_mask;
            wb_stall = 1'b1;
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                chk(in_ready == 1'b0, "R6", "ready during stall", in_ready, 0);
                chk(wb_valid && wb_warp == held_w && wb_mask == held_m,
                    "R6", "held warp", wb_warp, held_w);
                @(posedge clk); #1;
            end
            wb_stall = 1'b0;
        end
        drain();

        // R5: nothing lost
        chk(exp_q.size() == 0, "R5", "tokens outstanding", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule